// File: doc/BRIEF.md
# Peak-Hold Decimating Echo Capture Buffer

This block records one listen window of an ultrasonic echo amplitude stream into a small byte memory, for use during system tuning. The window is split into equal bins, one bin for each memory entry. Each bin is reduced to its largest sample, and that value is stored. Short peaks are therefore never lost to decimation, whatever window length is selected.

A capture is armed by an enable input and starts on a start pulse, which marks a burst-and-listen or listen-only command. The selected record-length code is latched at that moment. The bin length is scaled so that the whole window always fills every entry exactly. An active-low busy line is held low for the whole recording. While capture is enabled, a detection-inhibit flag tells downstream logic to stop object detection. The stored bytes are read back through a simple one-cycle read port once the recording has ended.

Top module: `echo_peak_capture`

## Requirements
- R1: The record-length code `len_code` (value c) is sampled when a capture starts and gives a bin of (c+1)×32 accepted samples. There are 128 bins, so the window is (c+1)×4096 samples. Changes to `len_code` during a capture have no effect.
- R2: Only cycles with `smp_valid` high count as samples. Entry k holds the largest sample among accepted samples k×B to k×B+B−1, where B is the bin length.
- R3: `busy_n` goes low in the cycle after an accepted start pulse. It returns high in the cycle after the last sample of bin 127 is accepted. Otherwise it stays high.
- R4: A start pulse while `cap_en` is 0 starts no capture: `busy_n` stays high and the memory is left unchanged.
- R5: A start pulse during a capture is ignored. The capture neither restarts nor changes length.
- R6: `detect_inhibit` equals the value `cap_en` had one cycle earlier.
- R7: When no capture is in progress, `rd_data` shows the entry at `rd_addr` one cycle after the address is applied. During a capture, `rd_data` holds its last value.
- R8: After reset, `busy_n` is 1, `detect_inhibit` is 0 and `rd_data` is 0.
- R9: The running maximum restarts at the first sample of each bin. A large value in one bin never carries into the next bin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_en | input | 1 | Capture enable |
| cap_start | input | 1 | One-cycle start pulse for a listen window |
| len_code | input | 2 | Record-length code |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 8 | Echo amplitude sample |
| rd_addr | input | 7 | Read address |
| rd_data | output | 8 | Stored entry, one-cycle latency |
| busy_n | output | 1 | Low while recording |
| detect_inhibit | output | 1 | Object detection disabled |

## Verification
The bench targets the following corner cases:

- **Bin boundaries.** A ramp pattern places a maximum at the first sample of one bin and small values in the next. A peak register that was not restarted per bin would leak that maximum into the following entry.
- **Strobe gaps.** Samples are sent with gaps between valid strobes. A counter that counted cycles rather than samples would misplace every bin and end `busy_n` early.
- **Changes mid-capture.** A second start pulse, a new length code and a new read address arrive in the middle of a capture. A design that restarted, re-read the code or let reads through would give a wrong busy length or wrong `rd_data`.
- **Disabled capture.** A start pulse with the enable low must leave both the memory and `busy_n` untouched.

// File: rtl/ecap_pkg.sv
// Package: shared types for the echo capture buffer.
// Assumes: only a two-state capture control is needed.
package ecap_pkg;
    typedef enum logic {
        CAP_IDLE = 1'b0,
        CAP_REC  = 1'b1
    } cap_state_t;
endpackage

// File: rtl/ecap_ctrl.sv
// Module: ecap_ctrl
// Runs the capture sequence: latches the bin length at start, counts
// accepted samples within a bin and bins within the window, and issues
// one memory write at the last sample of every bin.
// Assumes: cap_start is a single-cycle pulse; len_code is stable on it.
module ecap_ctrl
    import ecap_pkg::*;
#(
    parameter int DEPTH    = 128,
    parameter int CODE_W   = 2,
    parameter int BASE_BIN = 32,
    parameter int ADDR_W   = $clog2(DEPTH),
    parameter int BINC_W   = $clog2(BASE_BIN << CODE_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              cap_start,
    input  logic [CODE_W-1:0] len_code,
    input  logic              smp_valid,
    output logic              rec,
    output logic              accept,
    output logic              bin_first,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr
);
    cap_state_t        state_q;
    logic [BINC_W-1:0] bin_len_q;
    logic [BINC_W-1:0] bin_cnt_q;
    logic [ADDR_W-1:0] entry_q;
    logic [BINC_W-1:0] next_len;
    logic              bin_last;
    logic              win_done;

    // Bin length implied by the requested record-length code.
    always_comb begin
        next_len = BINC_W'((int'(len_code) + 1) * BASE_BIN);
    end

    // Sample and write qualifiers for the current cycle.
    always_comb begin
        rec       = (state_q == CAP_REC);
        accept    = rec && smp_valid;
        bin_last  = (bin_cnt_q == bin_len_q - BINC_W'(1));
        bin_first = (bin_cnt_q == '0);
        wr_en     = accept && bin_last;
        wr_addr   = entry_q;
        win_done  = wr_en && (entry_q == ADDR_W'(DEPTH - 1));
    end

    // Capture state, latched bin length, and sample/bin counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= CAP_IDLE;
            bin_len_q <= BINC_W'(BASE_BIN);
            bin_cnt_q <= '0;
            entry_q   <= '0;
        end else if (state_q == CAP_IDLE) begin
            if (cap_en && cap_start) begin
                state_q   <= CAP_REC;
                bin_len_q <= next_len;
                bin_cnt_q <= '0;
                entry_q   <= '0;
            end
        end else if (accept) begin
            if (bin_last) begin
                bin_cnt_q <= '0;
                entry_q   <= entry_q + ADDR_W'(1);
                if (win_done) begin
                    state_q <= CAP_IDLE;
                end
            end else begin
                bin_cnt_q <= bin_cnt_q + BINC_W'(1);
            end
        end
    end

    AST_IDLE_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!rec && !cap_en) |=> !rec); // R4
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (rec && !win_done) |=> (rec && $stable(bin_len_q) && (bin_cnt_q != '0 || entry_q != '0 || !$past(accept) || $past(bin_last)))); // R5
    AST_WINDOW_END: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |=> !rec); // R3
    AST_BIN_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rec |-> (bin_len_q >= BINC_W'(BASE_BIN) && bin_cnt_q < bin_len_q)); // R1
endmodule

// File: rtl/ecap_peak.sv
// Module: ecap_peak
// Keeps the running maximum of the current bin and presents the bin
// maximum that includes the present sample, for writing on the last sample.
// Assumes: bin_first marks the first accepted sample of each bin.
module ecap_peak #(
    parameter int SAMPLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept,
    input  logic                bin_first,
    input  logic [SAMPLE_W-1:0] sample,
    output logic [SAMPLE_W-1:0] bin_max
);
    logic [SAMPLE_W-1:0] peak_q;

    // Maximum so far including this sample; restarts at a bin's first sample.
    always_comb begin
        bin_max = (bin_first || sample > peak_q) ? sample : peak_q;
    end

    // Running peak register, updated on accepted samples only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            peak_q <= '0;
        end else if (accept) begin
            peak_q <= bin_max;
        end
    end

    AST_PEAK_COVERS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> peak_q >= $past(sample)); // R2
    AST_PEAK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && bin_first) |=> peak_q == $past(sample)); // R9
endmodule

// File: rtl/ecap_store.sv
// Module: ecap_store
// Byte array for the bin maxima with one write port and a registered read
// port that only updates while reads are allowed.
// Assumes: reads of never-written entries are not relied upon.
module ecap_store #(
    parameter int DEPTH    = 128,
    parameter int SAMPLE_W = 8,
    parameter int ADDR_W   = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [SAMPLE_W-1:0] wr_data,
    input  logic                rd_allow,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [SAMPLE_W-1:0] rd_data
);
    logic [SAMPLE_W-1:0] mem_q [DEPTH];

    // Write one bin maximum.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // Registered read, frozen while a capture is running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_allow) begin
            rd_data <= mem_q[rd_addr];
        end
    end

    AST_WRITE_ONLY_RECORDING: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !rd_allow); // R2
    AST_READ_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_allow |=> $stable(rd_data)); // R7
endmodule

// File: rtl/echo_peak_capture.sv
// Module: echo_peak_capture
// Top level: captures one listen window as per-bin peak bytes, drives the
// active-low busy line and the detection inhibit, and exposes a read port.
// Assumes: one sample per valid strobe; start pulses last one cycle.
module echo_peak_capture #(
    parameter int SAMPLE_W = 8,
    parameter int DEPTH    = 128,
    parameter int CODE_W   = 2,
    parameter int BASE_BIN = 32,
    localparam int ADDR_W  = $clog2(DEPTH),
    localparam int BINC_W  = $clog2(BASE_BIN << CODE_W) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_en,
    input  logic                cap_start,
    input  logic [CODE_W-1:0]   len_code,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [SAMPLE_W-1:0] rd_data,
    output logic                busy_n,
    output logic                detect_inhibit
);
    logic                rec;
    logic                accept;
    logic                bin_first;
    logic                wr_en;
    logic [ADDR_W-1:0]   wr_addr;
    logic [SAMPLE_W-1:0] bin_max;

    ecap_ctrl #(
        .DEPTH    (DEPTH),
        .CODE_W   (CODE_W),
        .BASE_BIN (BASE_BIN),
        .ADDR_W   (ADDR_W),
        .BINC_W   (BINC_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .cap_start (cap_start),
        .len_code  (len_code),
        .smp_valid (smp_valid),
        .rec       (rec),
        .accept    (accept),
        .bin_first (bin_first),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr)
    );

    ecap_peak #(
        .SAMPLE_W (SAMPLE_W)
    ) u_peak (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .bin_first (bin_first),
        .sample    (smp_data),
        .bin_max   (bin_max)
    );

    ecap_store #(
        .DEPTH    (DEPTH),
        .SAMPLE_W (SAMPLE_W),
        .ADDR_W   (ADDR_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (bin_max),
        .rd_allow (!rec),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    // Busy line is the inverted capture-state flop.
    always_comb begin
        busy_n = !rec;
    end

    // Detection inhibit follows the enable with one register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            detect_inhibit <= 1'b0;
        end else begin
            detect_inhibit <= cap_en;
        end
    end

    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_n && !(cap_start && cap_en)) |=> busy_n); // R3
    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_n && cap_start && cap_en) |=> !busy_n); // R3
endmodule

// File: tb/echo_peak_capture_bench.sv
// Directed bench for echo_peak_capture; each task checks its own results.
module echo_peak_capture_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cap_en = 1'b0;
    logic       cap_start = 1'b0;
    logic [1:0] len_code = 2'd0;
    logic       smp_valid = 1'b0;
    logic [7:0] smp_data = 8'd0;
    logic [6:0] rd_addr = 7'd0;
    logic [7:0] rd_data;
    logic       busy_n;
    logic       detect_inhibit;

    int checks = 0;
    int errors = 0;
    int busy_lo = 0;
    logic [7:0] exp_mem [128];

    echo_peak_capture u_echo_peak_capture (
        .clk            (clk),
        .rst_n          (rst_n),
        .cap_en         (cap_en),
        .cap_start      (cap_start),
        .len_code       (len_code),
        .smp_valid      (smp_valid),
        .smp_data       (smp_data),
        .rd_addr        (rd_addr),
        .rd_data        (rd_data),
        .busy_n         (busy_n),
        .detect_inhibit (detect_inhibit)
    );

    always #10 clk = ~clk;

    // Count cycles with busy low, sampled away from the active edge.
    always @(negedge clk) begin
        if (busy_n === 1'b0) busy_lo = busy_lo + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Read every entry and compare with the model.
    task automatic check_all(input string req);
        for (int a = 0; a < 128; a++) begin
            @(negedge clk);
            rd_addr = 7'(a);
            @(negedge clk);
            check(req, int'(rd_data), int'(exp_mem[a]));
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        check("R8 busy_n", int'(busy_n), 1);
        check("R8 detect_inhibit", int'(detect_inhibit), 0);
        check("R8 rd_data", int'(rd_data), 0);
        rst_n = 1'b1;
        cap_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R6 inhibit follows enable", int'(detect_inhibit), 1);
    endtask

    // One capture: code, gapped strobes, ramp pattern, mid-capture disturbance.
    task automatic run_cap(input string tag, input int code, input bit gap,
                           input bit ramp, input bit disturb);
        int bin = (code + 1) * 32;
        int win = bin * 128;
        logic [7:0] s;
        logic [7:0] held = 8'd0;
        if (disturb) begin
            @(negedge clk);
            rd_addr = 7'd5;
            @(negedge clk);
            held = rd_data;
        end
        @(negedge clk);
        cap_start = 1'b1;
        len_code = 2'(code);
        busy_lo = 0;
        @(negedge clk);
        cap_start = 1'b0;
        for (int i = 0; i < win; i++) begin
            if (ramp) s = ((i / bin) % 2 == 0) ? 8'(255 - (i % bin)) : 8'((i % bin) % 16);
            else      s = 8'($urandom);
            if (i % bin == 0 || s > exp_mem[i / bin]) exp_mem[i / bin] = s;
            smp_valid = 1'b1;
            smp_data = s;
            if (disturb && i == win / 2) begin
                cap_start = 1'b1;
                len_code = 2'(code ^ 1);
                rd_addr = 7'd9;
            end
            if (disturb && i == win / 2 + 3)
                check("R7 read frozen during capture", int'(rd_data), int'(held));
            @(negedge clk);
            smp_valid = 1'b0;
            cap_start = 1'b0;
            if (gap && i != win - 1) @(negedge clk);
        end
        @(negedge clk);
        @(negedge clk);
        check({tag, " busy released"}, int'(busy_n), 1);
        check({tag, " busy low length"}, busy_lo, gap ? 2 * win - 1 : win);
        check_all({tag, " entries"});
    endtask

    // Start with the enable low: no capture, memory untouched.
    task automatic test_disabled();
        @(negedge clk);
        cap_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R6 inhibit drops", int'(detect_inhibit), 0);
        busy_lo = 0;
        cap_start = 1'b1;
        @(negedge clk);
        cap_start = 1'b0;
        for (int i = 0; i < 40; i++) begin
            smp_valid = 1'b1;
            smp_data = 8'hFF;
            @(negedge clk);
        end
        smp_valid = 1'b0;
        check("R4 no busy when disabled", busy_lo, 0);
        check("R4 busy_n high", int'(busy_n), 1);
        check_all("R4 memory unchanged");
        cap_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R6 inhibit returns", int'(detect_inhibit), 1);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        run_cap("R1 R2 code0 random", 0, 1'b0, 1'b0, 1'b0);
        run_cap("R9 R1 code1 ramp", 1, 1'b0, 1'b1, 1'b0);
        run_cap("R2 R3 code0 gapped", 0, 1'b1, 1'b0, 1'b0);
        run_cap("R5 R1 code1 disturbed", 1, 1'b0, 1'b0, 1'b1);
        test_disabled();
        run_cap("R1 R3 code3 random", 3, 1'b0, 1'b0, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule